// File: doc/BRIEF.md
# Flash Protection Command Sequencer

This block runs the multi-packet dialogue that locks groups of flash pages against change. It sits behind a packet parser that has already checked framing and checksums. For each protect-type packet it gets one strobe, carrying a 32-bit value and a one-byte type code. It answers every packet one cycle later with a positive (0x06) or negative (0x07) response code.

A dialogue has three kinds of packet, which must come in order. An opening packet arms the sequencer. Any number of group packets then each name a 2 KiB region of four 512-byte pages. A key packet closes the dialogue. When the key packet arrives, the block emits a single strobe. That strobe carries the accumulated group mask and the key, split into an upper half for the flash controller's address register and a lower half for its data register.

Committed protection is sticky. The only way to remove it is a whole-array erase, which is an erase request with address zero and page count zero. Such an erase also abandons any dialogue in progress.

Top module: `flash_protect_sequencer`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `resp_valid`, `prot_valid` and `seq_busy` are 0 and `locked_mask` is all zeros.
- R2: Every cycle with `pkt_valid` high produces exactly one `resp_valid` pulse on the next cycle, with `resp_code` equal to 0x06 (accept) or 0x07 (reject). There is no response on any other cycle.
- R3: A packet of type 0x00 is accepted in any state, whatever its value. It sets `seq_busy` and discards any groups already gathered, so that a fresh dialogue begins.
- R4: While busy, a packet of type 0x0F whose value is below 32×0x800 is accepted. It adds bit value/0x800 to the pending mask, so 0x0 gives bit 0, 0x800 gives bit 1 and 0xF800 gives bit 31. Repeated groups accumulate.
- R5: While busy, a type 0x0F packet whose value is 0x10000 or more is rejected. The sequencer returns to idle and the pending groups are dropped.
- R6: While idle, a packet of type 0x0F or 0x01 is rejected, the sequencer stays idle, and no protection strobe is produced.
- R7: A packet of any type other than 0x00, 0x0F or 0x01 is rejected, and the sequencer returns to idle.
- R8: While busy, a type 0x01 packet is accepted. On the response cycle it raises `prot_valid` for exactly one cycle, with `prot_mask` equal to the pending mask, `prot_key_addr` equal to value[31:16] and `prot_key_data` equal to value[15:0]. The sequencer is then idle.
- R9: On the protection strobe, `prot_keyless` is 1 exactly when the key value is 0xFFFFFFFF.
- R10: `locked_mask` includes the strobed mask from the strobe cycle onward, and no bit of it ever clears except by R11.
- R11: An erase request with `erase_addr` 0 and `erase_pages` 0 clears `locked_mask` on the next cycle. It also returns the sequencer to idle, and any packet in the same cycle is rejected. Any other erase request changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | One protect-type packet presented this cycle |
| pkt_type | input | 8 | Packet type code |
| pkt_value | input | 32 | Packet 32-bit value (address or key) |
| erase_valid | input | 1 | Erase request seen this cycle |
| erase_addr | input | 32 | Erase start address |
| erase_pages | input | 8 | Erase page count |
| resp_valid | output | 1 | Response code valid |
| resp_code | output | 8 | 0x06 accept, 0x07 reject |
| seq_busy | output | 1 | Dialogue open, gathering groups |
| prot_valid | output | 1 | One-cycle protection request strobe |
| prot_mask | output | 32 | Groups to protect, bit n = region n×0x800 |
| prot_key_addr | output | 16 | Upper key half for the address register |
| prot_key_data | output | 16 | Lower key half for the data register |
| prot_keyless | output | 1 | Key is all ones, no key needed |
| locked_mask | output | 32 | Protection committed so far |

## Verification
A wrong sequencer state shows up at the ports on the very next packet. A stale open dialogue turns a reject that should follow an out-of-order key into an accept, and it does so on the cycle after that packet. A lost open state does the reverse. A corrupted pending mask stays hidden until the key packet, where it appears as a wrong `prot_mask` and a wrong `locked_mask` in the same cycle. So the stimulus always closes each dialogue with a key, and it mixes restarts and rejected groups in between. A protection bit that leaks or clears wrongly shows in `locked_mask` one cycle after the erase or strobe that caused it.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;

    localparam int KEY_W  = 32;
    localparam int HALF_W = KEY_W / 2;

    localparam logic [7:0] CODE_ACK = 8'h06;
    localparam logic [7:0] CODE_BEL = 8'h07;

    localparam logic [7:0] TYPE_OPEN  = 8'h00;
    localparam logic [7:0] TYPE_GROUP = 8'h0F;
    localparam logic [7:0] TYPE_KEY   = 8'h01;

    typedef enum logic [1:0] {
        PK_OPEN  = 2'd0,
        PK_GROUP = 2'd1,
        PK_KEY   = 2'd2,
        PK_BAD   = 2'd3
    } pkt_kind_e;

    typedef enum logic {
        SEQ_IDLE    = 1'b0,
        SEQ_COLLECT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [HALF_W-1:0] addr_half;
        logic [HALF_W-1:0] data_half;
        logic              keyless;
    } key_split_t;

    function automatic pkt_kind_e classify_type(input logic [7:0] t);
        pkt_kind_e k;
        case (t)
            TYPE_OPEN:  k = PK_OPEN;
            TYPE_GROUP: k = PK_GROUP;
            TYPE_KEY:   k = PK_KEY;
            default:    k = PK_BAD;
        endcase
        return k;
    endfunction

    function automatic key_split_t split_key(input logic [KEY_W-1:0] v);
        key_split_t s;
        s.addr_half = v[KEY_W-1:HALF_W];
        s.data_half = v[HALF_W-1:0];
        s.keyless   = &v;
        return s;
    endfunction

endpackage

// File: rtl/prot_type_decode.sv
module prot_type_decode
    import prot_seq_pkg::*;
(
    input  logic [7:0] type_code,
    output pkt_kind_e  kind
);
    assign kind = classify_type(type_code);
endmodule

// File: rtl/prot_group_map.sv
module prot_group_map
    import prot_seq_pkg::*;
#(
    parameter int MASK_W      = 32,
    parameter int GROUP_SHIFT = 11
) (
    input  logic [KEY_W-1:0]  addr,
    output logic [MASK_W-1:0] group_bit,
    output logic              in_range
);
    localparam int IDX_W = KEY_W - GROUP_SHIFT;

    logic [IDX_W-1:0] idx;
    assign idx      = addr[KEY_W-1:GROUP_SHIFT];
    assign in_range = (idx < IDX_W'(MASK_W));

    for (genvar g = 0; g < MASK_W; g++) begin : g_bit
        assign group_bit[g] = (idx == IDX_W'(g));
    end

    always_comb begin
        if (!$isunknown(addr)) begin
            // R4
            group_one_bit_chk: assert ($countones(group_bit) == (in_range ? 1 : 0));
        end
    end
endmodule

// File: rtl/prot_lock_reg.sv
module prot_lock_reg #(
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [MASK_W-1:0] commit_mask,
    input  logic              wipe,
    output logic [MASK_W-1:0] locked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= '0;
        end else if (wipe) begin
            locked <= '0;
        end else if (commit) begin
            locked <= locked | commit_mask;
        end
    end

    // R10
    lock_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wipe)) |-> ((locked & $past(locked)) == $past(locked)));

    // R11
    wipe_clears_chk: assert property (@(posedge clk) disable iff (rst)
        wipe |=> (locked == '0));
endmodule

// File: rtl/prot_seq_fsm.sv
module prot_seq_fsm
    import prot_seq_pkg::*;
#(
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    input  pkt_kind_e         kind,
    input  logic [KEY_W-1:0]  value,
    input  logic [MASK_W-1:0] group_bit,
    input  logic              group_ok,
    input  logic              abort,
    output logic              resp_valid,
    output logic [7:0]        resp_code,
    output logic              busy,
    output logic              prot_valid,
    output logic [MASK_W-1:0] prot_mask,
    output key_split_t        key,
    output logic              commit_now,
    output logic [MASK_W-1:0] commit_mask
);
    seq_state_e        state, nxt_state;
    logic [MASK_W-1:0] pending, nxt_pending;
    logic              accept;
    logic              fire;

    always_comb begin
        nxt_state   = state;
        nxt_pending = pending;
        accept      = 1'b0;
        fire        = 1'b0;
        if (abort) begin
            nxt_state   = SEQ_IDLE;
            nxt_pending = '0;
        end else if (pkt_valid) begin
            case (kind)
                PK_OPEN: begin
                    nxt_state   = SEQ_COLLECT;
                    nxt_pending = '0;
                    accept      = 1'b1;
                end
                PK_GROUP: begin
                    if (state == SEQ_COLLECT && group_ok) begin
                        nxt_pending = pending | group_bit;
                        accept      = 1'b1;
                    end else begin
                        nxt_state   = SEQ_IDLE;
                        nxt_pending = '0;
                    end
                end
                PK_KEY: begin
                    nxt_state   = SEQ_IDLE;
                    nxt_pending = '0;
                    if (state == SEQ_COLLECT) begin
                        fire   = 1'b1;
                        accept = 1'b1;
                    end
                end
                default: begin
                    nxt_state   = SEQ_IDLE;
                    nxt_pending = '0;
                end
            endcase
        end
    end

    assign commit_now  = fire;
    assign commit_mask = pending;
    assign busy        = (state == SEQ_COLLECT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            pending    <= '0;
            resp_valid <= 1'b0;
            resp_code  <= CODE_BEL;
            prot_valid <= 1'b0;
            prot_mask  <= '0;
            key        <= '0;
        end else begin
            state      <= nxt_state;
            pending    <= nxt_pending;
            resp_valid <= pkt_valid;
            resp_code  <= accept ? CODE_ACK : CODE_BEL;
            prot_valid <= fire;
            if (fire) begin
                prot_mask <= pending;
                key       <= split_key(value);
            end
        end
    end

    // R2
    resp_after_pkt_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(pkt_valid));

    // R2
    resp_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_code == CODE_ACK || resp_code == CODE_BEL));

    // R8
    strobe_ack_chk: assert property (@(posedge clk) disable iff (rst)
        prot_valid |-> (resp_valid && resp_code == CODE_ACK && state == SEQ_IDLE));

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        prot_valid |=> !prot_valid);

    // R6
    idle_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !abort && state == SEQ_IDLE && kind != PK_OPEN)
            |=> (resp_code == CODE_BEL && !prot_valid));

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> (state == SEQ_IDLE && !prot_valid));
endmodule

// File: rtl/flash_protect_sequencer.sv
module flash_protect_sequencer
    import prot_seq_pkg::*;
#(
    parameter int MASK_W      = 32,
    parameter int GROUP_SHIFT = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    input  logic [7:0]        pkt_type,
    input  logic [KEY_W-1:0]  pkt_value,
    input  logic              erase_valid,
    input  logic [31:0]       erase_addr,
    input  logic [7:0]        erase_pages,
    output logic              resp_valid,
    output logic [7:0]        resp_code,
    output logic              seq_busy,
    output logic              prot_valid,
    output logic [MASK_W-1:0] prot_mask,
    output logic [HALF_W-1:0] prot_key_addr,
    output logic [HALF_W-1:0] prot_key_data,
    output logic              prot_keyless,
    output logic [MASK_W-1:0] locked_mask
);
    pkt_kind_e         kind;
    logic [MASK_W-1:0] group_bit;
    logic              group_ok;
    logic              wipe;
    logic              commit_now;
    logic [MASK_W-1:0] commit_mask;
    key_split_t        key;

    assign wipe = erase_valid && (erase_addr == '0) && (erase_pages == '0);

    prot_type_decode u_decode (
        .type_code (pkt_type),
        .kind      (kind)
    );

    prot_group_map #(
        .MASK_W      (MASK_W),
        .GROUP_SHIFT (GROUP_SHIFT)
    ) u_map (
        .addr      (pkt_value),
        .group_bit (group_bit),
        .in_range  (group_ok)
    );

    prot_seq_fsm #(
        .MASK_W (MASK_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pkt_valid   (pkt_valid),
        .kind        (kind),
        .value       (pkt_value),
        .group_bit   (group_bit),
        .group_ok    (group_ok),
        .abort       (wipe),
        .resp_valid  (resp_valid),
        .resp_code   (resp_code),
        .busy        (seq_busy),
        .prot_valid  (prot_valid),
        .prot_mask   (prot_mask),
        .key         (key),
        .commit_now  (commit_now),
        .commit_mask (commit_mask)
    );

    prot_lock_reg #(
        .MASK_W (MASK_W)
    ) u_lock (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit_now),
        .commit_mask (commit_mask),
        .wipe        (wipe),
        .locked      (locked_mask)
    );

    assign prot_key_addr = key.addr_half;
    assign prot_key_data = key.data_half;
    assign prot_keyless  = key.keyless;
endmodule

// File: tb/flash_protect_sequencer_test.sv
`timescale 1ns/1ps
module flash_protect_sequencer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        pkt_valid;
    logic [7:0]  pkt_type;
    logic [31:0] pkt_value;
    logic        erase_valid;
    logic [31:0] erase_addr;
    logic [7:0]  erase_pages;
    logic        resp_valid;
    logic [7:0]  resp_code;
    logic        seq_busy;
    logic        prot_valid;
    logic [31:0] prot_mask;
    logic [15:0] prot_key_addr;
    logic [15:0] prot_key_data;
    logic        prot_keyless;
    logic [31:0] locked_mask;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    flash_protect_sequencer uut (
        .clk           (clk),
        .rst           (rst),
        .pkt_valid     (pkt_valid),
        .pkt_type      (pkt_type),
        .pkt_value     (pkt_value),
        .erase_valid   (erase_valid),
        .erase_addr    (erase_addr),
        .erase_pages   (erase_pages),
        .resp_valid    (resp_valid),
        .resp_code     (resp_code),
        .seq_busy      (seq_busy),
        .prot_valid    (prot_valid),
        .prot_mask     (prot_mask),
        .prot_key_addr (prot_key_addr),
        .prot_key_data (prot_key_data),
        .prot_keyless  (prot_keyless),
        .locked_mask   (locked_mask)
    );

    // Row layout: type[106:99] value[98:67] ack[66] busy[65] strobe[64] mask[63:32] locked[31:0]
    localparam int NV = 18;
    localparam logic [106:0] VEC [NV] = '{
        {8'h01, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0},                  // R6 key while idle
        {8'h0F, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0},                  // R6 group while idle
        {8'h00, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0},                  // R3 value ignored
        {8'h0F, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0},                  // R4 bit 0
        {8'h0F, 32'h0000_0800, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0},                  // R4 bit 1
        {8'h0F, 32'h0000_F800, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0},                  // R4 bit 31
        {8'h01, 32'h1234_5678, 1'b1, 1'b0, 1'b1, 32'h8000_0003, 32'h8000_0003},  // R8 R10
        {8'h0F, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 32'h0, 32'h8000_0003},          // R6 after close
        {8'h00, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0, 32'h8000_0003},          // R3
        {8'h0F, 32'h0001_0000, 1'b0, 1'b0, 1'b0, 32'h0, 32'h8000_0003},          // R5 out of range
        {8'h01, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0, 32'h8000_0003},          // R5 dialogue dropped
        {8'h00, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0, 32'h8000_0003},          // R3
        {8'h33, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0, 32'h8000_0003},          // R7 unknown type
        {8'h00, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0, 32'h8000_0003},          // R3
        {8'h0F, 32'h0000_1800, 1'b1, 1'b1, 1'b0, 32'h0, 32'h8000_0003},          // R4 bit 3
        {8'h00, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0, 32'h8000_0003},          // R3 restart clears
        {8'h0F, 32'h0000_2000, 1'b1, 1'b1, 1'b0, 32'h0, 32'h8000_0003},          // R4 bit 4
        {8'h01, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 32'h0000_0010, 32'h8000_0013}   // R8 R9 R10
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with outputs settled.
    task automatic send(input logic [7:0] t, input logic [31:0] v);
        pkt_valid = 1'b1;
        pkt_type  = t;
        pkt_value = v;
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic erase(input logic [31:0] a, input logic [7:0] n);
        erase_valid = 1'b1;
        erase_addr  = a;
        erase_pages = n;
        @(negedge clk);
        erase_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        pkt_valid = 1'b0; pkt_type = '0; pkt_value = '0;
        erase_valid = 1'b0; erase_addr = '0; erase_pages = '0;
        repeat (4) @(negedge clk);
        // R1 state while in reset
        check("R1", "resp_valid in reset", 32'(resp_valid), 32'd0);
        check("R1", "locked in reset", locked_mask, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        // R1 state after reset release
        check("R1", "resp_valid", 32'(resp_valid), 32'd0);
        check("R1", "prot_valid", 32'(prot_valid), 32'd0);
        check("R1", "seq_busy", 32'(seq_busy), 32'd0);
        check("R1", "locked_mask", locked_mask, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [106:0] v;
            v = VEC[i];
            send(v[106:99], v[98:67]);
            // R2 one response, code by acceptance
            check("R2", $sformatf("row %0d resp_valid", i), 32'(resp_valid), 32'd1);
            check("R2", $sformatf("row %0d resp_code", i), 32'(resp_code),
                  v[66] ? 32'h06 : 32'h07);
            check("R3", $sformatf("row %0d seq_busy", i), 32'(seq_busy), 32'(v[65]));
            check("R8", $sformatf("row %0d prot_valid", i), 32'(prot_valid), 32'(v[64]));
            check("R10", $sformatf("row %0d locked_mask", i), locked_mask, v[31:0]);
            if (v[64]) begin
                check("R8", $sformatf("row %0d prot_mask", i), prot_mask, v[63:32]);
                check("R8", $sformatf("row %0d key addr half", i), 32'(prot_key_addr),
                      32'(v[98:83]));
                check("R8", $sformatf("row %0d key data half", i), 32'(prot_key_data),
                      32'(v[82:67]));
                check("R9", $sformatf("row %0d keyless", i), 32'(prot_keyless),
                      32'(v[98:67] == 32'hFFFF_FFFF));
            end
        end

        // R8 strobe lasts one cycle; R2 no response without a packet
        @(negedge clk);
        check("R8", "strobe dropped", 32'(prot_valid), 32'd0);
        check("R2", "no packet no response", 32'(resp_valid), 32'd0);

        // R11 ordinary erases leave protection alone
        erase(32'h0000_0200, 8'd0);
        check("R11", "erase addr 0x200", locked_mask, 32'h8000_0013);
        erase(32'h0000_0000, 8'd3);
        check("R11", "erase 3 pages", locked_mask, 32'h8000_0013);
        // R10 a later accepted dialogue only adds bits
        send(8'h00, 32'h0);
        send(8'h0F, 32'h0000_0800);
        send(8'h01, 32'hA5A5_0000);
        check("R10", "re-lock keeps bits", locked_mask, 32'h8000_0013);
        check("R9", "keyed not keyless", 32'(prot_keyless), 32'd0);
        // R11 whole-array erase clears
        erase(32'h0000_0000, 8'd0);
        check("R11", "mass erase clears", locked_mask, 32'h0);

        // R11 mass erase abandons an open dialogue
        send(8'h00, 32'h0);
        send(8'h0F, 32'h0000_0800);
        erase(32'h0, 8'd0);
        check("R11", "busy after abort", 32'(seq_busy), 32'd0);
        send(8'h01, 32'h1111_2222);
        check("R11", "key after abort rejected", 32'(resp_code), 32'h07);
        check("R11", "no strobe after abort", 32'(prot_valid), 32'd0);

        // R11 packet in the same cycle as a mass erase is rejected
        send(8'h00, 32'h0);
        erase_valid = 1'b1; erase_addr = '0; erase_pages = '0;
        send(8'h01, 32'h3333_4444);
        erase_valid = 1'b0;
        check("R11", "same-cycle key code", 32'(resp_code), 32'h07);
        check("R11", "same-cycle strobe", 32'(prot_valid), 32'd0);
        check("R11", "same-cycle locked", locked_mask, 32'h0);

        // R1 reset wipes committed state
        send(8'h00, 32'h0);
        send(8'h0F, 32'h0000_3000);
        send(8'h01, 32'h0);
        check("R10", "bit 6 locked", locked_mask, 32'h0000_0040);
        send(8'h00, 32'h0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "locked after reset", locked_mask, 32'h0);
        check("R1", "busy after reset", 32'(seq_busy), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule